// File: doc/BRIEF.md
# Register Condition Evaluation Unit

This unit decides conditions for a machine that keeps no flags register. Every test looks at one 64-bit general-purpose value: whether it is zero, what its sign is, or what its lowest bit is. One evaluation serves both conditional moves and conditional branches. The unit also runs a second, separate group of two-operand compares. Each compare produces a boolean that is exactly 0 or 1.

An operation is presented on one cycle with `in_valid` high. It carries a mode bit that picks a condition test or a compare, a 3-bit selector, the tested operand, and a second operand. The second operand is either a register value or a zero-extended immediate. The operation also carries the old destination value. One clock later the unit presents its outputs together with a valid bit:
- the condition/compare bit,
- a destination write-enable,
- the 64-bit result.

A branch unit reads only the condition bit. A register writeback stage reads the result and the write-enable.

Top module: `cond_unit`

## Requirements
- R1: After reset, `out_valid`, `out_cond` and `out_wr_en` are 0 and `out_result` is 0.
- R2: `out_valid` equals the `in_valid` of the previous clock cycle. The other outputs reflect an operation on the cycle after it was accepted.
- R3: In condition mode (`in_is_cmp`=0), `in_sel` picks the test on `in_ra`. The codes are 0 zero, 1 non-zero, 2 signed ≥0, 3 signed >0, 4 signed ≤0, 5 signed <0, 6 low bit clear, 7 low bit set. `out_cond` is the test outcome.
- R4: Condition tests and compares use all 64 bits. A value whose only set bits lie above bit 31 is non-zero. Bit 63 is the sign.
- R5: In condition mode with the test true, `out_result` equals the second operand and `out_wr_en` is 1.
- R6: In condition mode with the test false, `out_result` equals `in_old_c` and `out_wr_en` is 0.
- R7: In compare mode (`in_is_cmp`=1), `in_sel` picks the relation of `in_ra` to the second operand. The codes are 0 equal, 1 signed less-than, 2 signed less-or-equal, 3 unsigned less-than, 4 unsigned less-or-equal.
- R8: In compare mode, `out_result` is the compare bit zero-extended to 64 bits, `out_cond` equals that bit, and `out_wr_en` is 1.
- R9: With `in_use_imm`=1, the second operand is `in_imm` zero-extended to 64 bits. With `in_use_imm`=0 it is `in_rb`.
- R10: Compare codes 5 to 7 yield a result of 0.
- R11: While `in_valid` is low, `out_result`, `out_cond` and `out_wr_en` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_is_cmp | input | 1 | 1 = compare mode, 0 = condition mode |
| in_sel | input | 3 | Condition or compare code |
| in_use_imm | input | 1 | Second operand comes from the immediate |
| in_imm | input | IMM_W | Immediate operand |
| in_ra | input | DATA_W | Tested / first operand |
| in_rb | input | DATA_W | Register second operand |
| in_old_c | input | DATA_W | Current destination value |
| out_valid | output | 1 | Result valid |
| out_cond | output | 1 | Condition or compare outcome |
| out_wr_en | output | 1 | Destination write-enable |
| out_result | output | DATA_W | Value for the destination |

## Verification
The hardest situations to reach are the ones that tell a full-width test apart from a narrower one. One is a value that is non-zero only above bit 31. Another is a value whose top bit gives opposite answers under the signed and unsigned compares. The stimulus builds these patterns on purpose:
- bit 63 alone,
- bit 32 alone,
- all ones against 1.

It then runs every condition and compare code over them, with the destination preloaded so a false move is visible.

// File: rtl/cond_pkg.sv
package cond_pkg;
  typedef enum logic [2:0] {
    C_ZERO = 3'd0, C_NZ = 3'd1, C_GEZ = 3'd2, C_GTZ = 3'd3,
    C_LEZ  = 3'd4, C_LTZ = 3'd5, C_EVEN = 3'd6, C_ODD = 3'd7
  } cond_code_e;

  typedef enum logic [2:0] {
    K_EQ = 3'd0, K_SLT = 3'd1, K_SLE = 3'd2, K_ULT = 3'd3, K_ULE = 3'd4
  } cmp_code_e;
endpackage

// File: rtl/opnd_sel.sv
module opnd_sel #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8
) (
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] rb,
  output logic [DATA_W-1:0] opnd
);
  logic [DATA_W-1:0] imm_ext;
  generate
    if (IMM_W < DATA_W) begin : g_pad
      assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm};
    end else begin : g_full
      assign imm_ext = imm[DATA_W-1:0];
    end
  endgenerate
  assign opnd = use_imm ? imm_ext : rb;
endmodule

// File: rtl/cond_eval.sv
module cond_eval #(
  parameter int DATA_W = 64
) (
  input  logic [2:0]        sel,
  input  logic [DATA_W-1:0] a,
  output logic              hit
);
  import cond_pkg::*;

  function automatic logic test_value(input logic [2:0] code, input logic [DATA_W-1:0] v);
    logic is_zero, is_neg;
    is_zero = (v == '0);
    is_neg  = v[DATA_W-1];
    case (cond_code_e'(code))
      C_ZERO:  return is_zero;
      C_NZ:    return !is_zero;
      C_GEZ:   return !is_neg;
      C_GTZ:   return !is_neg && !is_zero;
      C_LEZ:   return is_neg || is_zero;
      C_LTZ:   return is_neg;
      C_EVEN:  return !v[0];
      default: return v[0];
    endcase
  endfunction

  assign hit = test_value(sel, a);
endmodule

// File: rtl/cmp_eval.sv
module cmp_eval #(
  parameter int DATA_W = 64
) (
  input  logic [2:0]        sel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              bit_out
);
  import cond_pkg::*;

  function automatic logic relate(input logic [2:0] code,
                                  input logic [DATA_W-1:0] x,
                                  input logic [DATA_W-1:0] y);
    logic eq, slt, ult;
    eq  = (x == y);
    slt = ($signed(x) < $signed(y));
    ult = (x < y);
    case (code)
      K_EQ:    return eq;
      K_SLT:   return slt;
      K_SLE:   return slt || eq;
      K_ULT:   return ult;
      K_ULE:   return ult || eq;
      default: return 1'b0;
    endcase
  endfunction

  assign bit_out = relate(sel, a, b);
endmodule

// File: rtl/cond_unit.sv
module cond_unit #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_is_cmp,
  input  logic [2:0]        in_sel,
  input  logic              in_use_imm,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [DATA_W-1:0] in_ra,
  input  logic [DATA_W-1:0] in_rb,
  input  logic [DATA_W-1:0] in_old_c,
  output logic              out_valid,
  output logic              out_cond,
  output logic              out_wr_en,
  output logic [DATA_W-1:0] out_result
);
  logic [DATA_W-1:0] opnd_b;
  logic              cond_hit;
  logic              cmp_bit;
  logic              nxt_cond;
  logic              nxt_wr_en;
  logic [DATA_W-1:0] nxt_result;

  opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .use_imm(in_use_imm), .imm(in_imm), .rb(in_rb), .opnd(opnd_b)
  );

  cond_eval #(.DATA_W(DATA_W)) u_cond (
    .sel(in_sel), .a(in_ra), .hit(cond_hit)
  );

  cmp_eval #(.DATA_W(DATA_W)) u_cmp (
    .sel(in_sel), .a(in_ra), .b(opnd_b), .bit_out(cmp_bit)
  );

  always_comb begin
    if (in_is_cmp) begin
      nxt_cond   = cmp_bit;
      nxt_wr_en  = 1'b1;
      nxt_result = {{(DATA_W-1){1'b0}}, cmp_bit};
    end else begin
      nxt_cond   = cond_hit;
      nxt_wr_en  = cond_hit;
      nxt_result = cond_hit ? opnd_b : in_old_c;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_cond   <= 1'b0;
      out_wr_en  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_cond   <= nxt_cond;
        out_wr_en  <= nxt_wr_en;
        out_result <= nxt_result;
      end
    end
  end
endmodule

// File: rtl/cond_unit_chk.sv
module cond_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_is_cmp,
  input logic [2:0]        in_sel,
  input logic [DATA_W-1:0] in_ra,
  input logic [DATA_W-1:0] in_old_c,
  input logic [DATA_W-1:0] opnd_b,
  input logic              cond_hit,
  input logic              out_valid,
  input logic              out_cond,
  input logic              out_wr_en,
  input logic [DATA_W-1:0] out_result
);
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_odd_test_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_is_cmp && in_sel == 3'd7) |=> (out_cond == $past(in_ra[0])));
  p_move_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_is_cmp && cond_hit) |=> (out_wr_en && out_result == $past(opnd_b)));
  p_move_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_is_cmp && !cond_hit) |=> (!out_wr_en && out_result == $past(in_old_c)));
  p_cmp_bool_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_is_cmp) |=>
      (out_result[DATA_W-1:1] == '0 && out_wr_en && out_cond == out_result[0]));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_cond) && $stable(out_wr_en)));
endmodule

bind cond_unit cond_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_cmp(in_is_cmp),
  .in_sel(in_sel), .in_ra(in_ra), .in_old_c(in_old_c), .opnd_b(opnd_b),
  .cond_hit(cond_hit), .out_valid(out_valid), .out_cond(out_cond),
  .out_wr_en(out_wr_en), .out_result(out_result)
);

// File: tb/tb_cond_unit.sv
`timescale 1ns/1ps
module tb_cond_unit;
  localparam int DW = 64;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_is_cmp = 1'b0;
  logic [2:0]    in_sel = '0;
  logic          in_use_imm = 1'b0;
  logic [IW-1:0] in_imm = '0;
  logic [DW-1:0] in_ra = '0, in_rb = '0, in_old_c = '0;
  logic          out_valid, out_cond, out_wr_en;
  logic [DW-1:0] out_result;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  cond_unit #(.DATA_W(DW), .IMM_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_cmp(in_is_cmp),
    .in_sel(in_sel), .in_use_imm(in_use_imm), .in_imm(in_imm), .in_ra(in_ra),
    .in_rb(in_rb), .in_old_c(in_old_c), .out_valid(out_valid),
    .out_cond(out_cond), .out_wr_en(out_wr_en), .out_result(out_result)
  );

  // Reference: sign is the top bit, zero means every bit clear.
  function automatic bit ref_cond(input int code, input logic [DW-1:0] v);
    longint s = longint'(v);
    case (code)
      0: return s == 0;
      1: return s != 0;
      2: return s >= 0;
      3: return s > 0;
      4: return s <= 0;
      5: return s < 0;
      6: return (v % 2) == 0;
      default: return (v % 2) == 1;
    endcase
  endfunction

  function automatic bit ref_cmp(input int code, input logic [DW-1:0] x, input logic [DW-1:0] y);
    longint sx = longint'(x);
    longint sy = longint'(y);
    longint unsigned ux = x;
    longint unsigned uy = y;
    case (code)
      0: return ux == uy;
      1: return sx < sy;
      2: return sx <= sy;
      3: return ux < uy;
      4: return ux <= uy;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive one operation, then sample one ns after the capturing edge.
  task automatic issue(input bit cmp, input int sel, input bit use_imm, input logic [IW-1:0] imm,
                       input logic [DW-1:0] ra, input logic [DW-1:0] rb, input logic [DW-1:0] oldc);
    @(negedge clk);
    in_valid = 1'b1; in_is_cmp = cmp; in_sel = 3'(sel); in_use_imm = use_imm;
    in_imm = imm; in_ra = ra; in_rb = rb; in_old_c = oldc;
    @(posedge clk); #1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic move_case(input string req, input int sel, input logic [DW-1:0] ra,
                           input logic [DW-1:0] rb, input logic [DW-1:0] oldc);
    bit c = ref_cond(sel, ra);
    issue(1'b0, sel, 1'b0, '0, ra, rb, oldc);
    check(req, {63'b0, out_cond}, {63'b0, c});
    check({req, "/R5-R6 wr_en"}, {63'b0, out_wr_en}, {63'b0, c});
    check({req, "/R5-R6 result"}, out_result, c ? rb : oldc);
  endtask

  task automatic cmp_case(input string req, input int sel, input logic [DW-1:0] ra, input logic [DW-1:0] rb);
    bit c = ref_cmp(sel, ra, rb);
    issue(1'b1, sel, 1'b0, '0, ra, rb, 64'hDEAD_BEEF_0000_1111);
    check({req, "/R8 result"}, out_result, {63'b0, c});
    check({req, "/R8 cond"}, {63'b0, out_cond}, {63'b0, c});
    check({req, "/R8 wr_en"}, {63'b0, out_wr_en}, 64'd1);
  endtask

  task automatic t_reset;
    check("R1 valid", {63'b0, out_valid}, 64'd0);
    check("R1 cond", {63'b0, out_cond}, 64'd0);
    check("R1 wr_en", {63'b0, out_wr_en}, 64'd0);
    check("R1 result", out_result, 64'd0);
  endtask

  task automatic t_valid;
    @(negedge clk);
    in_valid = 1'b1; in_is_cmp = 1'b0; in_sel = 3'd1; in_ra = 64'd5; in_rb = 64'd9; in_old_c = 64'd3;
    check("R2 before edge", {63'b0, out_valid}, 64'd0);
    @(posedge clk); #1;
    check("R2 valid rises", {63'b0, out_valid}, 64'd1);
    check("R2 result", out_result, 64'd9);
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    check("R2 valid falls", {63'b0, out_valid}, 64'd0);
  endtask

  task automatic t_conditions;
    logic [DW-1:0] pats [5] = '{64'd0, 64'd1, 64'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE};
    for (int p = 0; p < 5; p++)
      for (int s = 0; s < 8; s++)
        move_case("R3 cond", s, pats[p], 64'h0123_4567_89AB_CDEF, 64'h5555_0000_AAAA_0000);
  endtask

  task automatic t_full_width;
    for (int s = 0; s < 8; s++) begin
      move_case("R4 bit63", s, 64'h8000_0000_0000_0000, 64'h77, 64'h11);
      move_case("R4 bit32", s, 64'h0000_0001_0000_0000, 64'h77, 64'h11);
    end
    cmp_case("R4 eq high", 0, 64'h0000_0001_0000_0005, 64'd5);
  endtask

  task automatic t_cmov;
    move_case("R5 taken", 0, 64'd0, 64'hCAFE_F00D_1234_5678, 64'h1);
    move_case("R6 kept", 0, 64'd7, 64'hCAFE_F00D_1234_5678, 64'hBBBB_CCCC_DDDD_EEEE);
  endtask

  task automatic t_compare;
    logic [DW-1:0] xs [4] = '{64'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'h8000_0000_0000_0000};
    logic [DW-1:0] ys [4] = '{64'd3, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF};
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 5; s++)
        cmp_case("R7 cmp", s, xs[p], ys[p]);
  endtask

  task automatic t_imm;
    issue(1'b1, 0, 1'b1, 8'hF0, 64'h0000_0000_0000_00F0, 64'd1, 64'd0);
    check("R9 imm eq zero-extended", out_result, 64'd1);
    issue(1'b1, 3, 1'b1, 8'hFF, 64'h0000_0000_0000_0100, 64'd0, 64'd0);
    check("R9 imm unsigned", out_result, 64'd0);
    issue(1'b0, 7, 1'b1, 8'h80, 64'd1, 64'hFFFF, 64'd0);
    check("R9 imm move", out_result, 64'h0000_0000_0000_0080);
  endtask

  task automatic t_reserved;
    for (int s = 5; s < 8; s++) begin
      issue(1'b1, s, 1'b0, '0, 64'd0, 64'd0, 64'hFF);
      check("R10 reserved", out_result, 64'd0);
    end
  endtask

  task automatic t_hold;
    logic [DW-1:0] kept;
    issue(1'b0, 1, 1'b0, '0, 64'd2, 64'h4444, 64'd0);
    kept = out_result;
    @(negedge clk);
    in_is_cmp = 1'b1; in_sel = 3'd0; in_ra = 64'd0; in_rb = 64'd0; in_old_c = 64'd9;
    repeat (3) @(posedge clk);
    #1;
    check("R11 hold result", out_result, kept);
    check("R11 hold wr_en", {63'b0, out_wr_en}, 64'd1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_valid();
    t_conditions();
    t_full_width();
    t_cmov();
    t_compare();
    t_imm();
    t_reserved();
    t_hold();
    finish_run();
  end
endmodule